// File: doc/BRIEF.md
# Lockable Two-Half Security Register

This block is a 128-bit security register made of two 64-bit halves. The lower half holds a unique value fixed when the design is built and can never be changed. The upper half is blank (all ones) after reset. Software can program it through a four-write command sequence until it issues a lock sequence. After that the upper half is read-only for good.

The register is visible only in identification mode. This mode is entered with a three-write sequence and left with a single exit write. While the block is in identification mode, no command other than the exit write is accepted. Reads are registered: read data appears in the cycle after the read strobe and holds until the next read.

The command keys are AA at 555h, then 55 at 2AAh, then an opcode at 555h. The opcodes are C0 to program, 60 to lock and 90 to enter identification mode. Only the low data byte is compared for keys and opcodes. The exit write is any write whose low byte is F0. The fourth write of a program or lock sequence may go to any address.

Top module: `prot_reg_top`

## Requirements
- R1: After reset the block is outside identification mode, `rdata` is FFFFh, the upper half reads all ones, and the half is unlocked.
- R2: The writes AA@555h, 55@2AAh, 90@555h enter identification mode. Outside that mode every read returns FFFFh.
- R3: In identification mode, addresses 081h–084h return the fixed half, 16 bits each, least significant word first at 081h.
- R4: The writes AA@555h, 55@2AAh, C0@555h followed by a write to 085h–088h replace that upper-half word with the AND of its old value and the data. Bits can only go from 1 to 0.
- R5: A program sequence whose fourth write targets 081h–084h changes nothing and raises `prot_viol` for exactly one cycle.
- R6: The writes AA@555h, 55@2AAh, 60@555h followed by a fourth write with data bit 1 equal to 0 lock the upper half. Every other data bit of that write is ignored. If bit 1 is 1, the lock is not set.
- R7: In identification mode, a read of 080h returns bit 1 = 0 when the upper half is locked and 1 when it is unlocked. All other bits read 1.
- R8: After the lock, a program sequence to 085h–088h leaves the word unchanged and raises `prot_viol` for one cycle. Once set, the lock stays set until reset.
- R9: In identification mode, any write whose low byte is not F0 is ignored, command sequences included. A write with low byte F0 leaves the mode.
- R10: A key write that does not match its expected address and data abandons the sequence, and the writes after it take no effect.
- R11: In identification mode, addresses outside 080h–088h read FFFFh.
- R12: `rdata` updates one cycle after a cycle with `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 12 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| prot_viol | output | 1 | One-cycle pulse when a program is refused |

## Verification
The bench programs one word twice with overlapping patterns. A design that overwrote the word instead of ANDing it would show the second pattern in place of their intersection. It sends lock writes with bit 1 set and with bit 1 clear and other bits set, which catches a decoder that tests the wrong bit or the whole byte. It attempts program sequences while in identification mode, to the fixed half, and to the locked half. Each attempt is then read back, so a missing guard shows up as changed data or a missing violation pulse. Broken key sequences and unmapped addresses are also read back, to catch a sequencer that does not restart or a mux that leaks stale data.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 16;
    localparam int HALF_BITS  = 64;
    localparam int HALF_WORDS = HALF_BITS / WORD_W;
    localparam int IDX_W      = $clog2(HALF_WORDS);

    localparam logic [ADDR_W-1:0] KEY1_ADDR  = 12'h555;
    localparam logic [ADDR_W-1:0] KEY2_ADDR  = 12'h2AA;
    localparam logic [ADDR_W-1:0] STAT_ADDR  = 12'h080;
    localparam logic [ADDR_W-1:0] FIXED_BASE = 12'h081;

    localparam logic [7:0] KEY1_DATA = 8'hAA;
    localparam logic [7:0] KEY2_DATA = 8'h55;
    localparam logic [7:0] OP_PROG   = 8'hC0;
    localparam logic [7:0] OP_LOCK   = 8'h60;
    localparam logic [7:0] OP_ID_IN  = 8'h90;
    localparam logic [7:0] OP_ID_OUT = 8'hF0;

    localparam int LOCK_BIT = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG,
        SQ_LOCK
    } seq_state_e;

    typedef enum logic [1:0] {
        RG_STAT,
        RG_FIXED,
        RG_USER,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic                prog_fire;
        logic                lock_fire;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
    } cmd_t;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - FIXED_BASE;
        if (a == STAT_ADDR)
            return RG_STAT;
        else if (a >= FIXED_BASE && off < ADDR_W'(HALF_WORDS))
            return RG_FIXED;
        else if (a >= FIXED_BASE && off < ADDR_W'(2 * HALF_WORDS))
            return RG_USER;
        else
            return RG_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] word_idx(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - FIXED_BASE;
        return off[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/pr_cmd_seq.sv
module pr_cmd_seq
    import pr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              id_mode,
    output cmd_t              cmd
);

    seq_state_e state_q, state_d;
    logic       id_q, id_d;

    always_comb begin
        state_d       = state_q;
        id_d          = id_q;
        cmd.prog_fire = 1'b0;
        cmd.lock_fire = 1'b0;
        cmd.addr      = addr;
        cmd.data      = wdata;
        if (wr_en) begin
            if (id_q) begin
                // only the exit write is honoured in identification mode
                if (wdata[7:0] == OP_ID_OUT)
                    id_d = 1'b0;
                state_d = SQ_IDLE;
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        if (addr == KEY1_ADDR && wdata[7:0] == KEY1_DATA)
                            state_d = SQ_KEY1;
                    end
                    SQ_KEY1: begin
                        if (addr == KEY2_ADDR && wdata[7:0] == KEY2_DATA)
                            state_d = SQ_KEY2;
                        else
                            state_d = SQ_IDLE;
                    end
                    SQ_KEY2: begin
                        state_d = SQ_IDLE;
                        if (addr == KEY1_ADDR) begin
                            case (wdata[7:0])
                                OP_PROG:  state_d = SQ_PROG;
                                OP_LOCK:  state_d = SQ_LOCK;
                                OP_ID_IN: id_d    = 1'b1;
                                default:  state_d = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PROG: begin
                        cmd.prog_fire = 1'b1;
                        state_d       = SQ_IDLE;
                    end
                    SQ_LOCK: begin
                        cmd.lock_fire = ~wdata[LOCK_BIT];
                        state_d       = SQ_IDLE;
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            id_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    assign id_mode = id_q;

endmodule

// File: rtl/pr_user_store.sv
module pr_user_store
    import pr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_t                 cmd,
    output logic [HALF_BITS-1:0] user_bits,
    output logic                 locked,
    output logic                 viol
);

    region_e          tgt;
    logic [IDX_W-1:0] tgt_idx;
    logic             refused;

    always_comb begin
        tgt     = classify(cmd.addr);
        tgt_idx = word_idx(cmd.addr);
        refused = cmd.prog_fire &&
                  (tgt == RG_FIXED || (tgt == RG_USER && locked));
    end

    for (genvar w = 0; w < HALF_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '1;
            else if (cmd.prog_fire && tgt == RG_USER && !locked &&
                     tgt_idx == IDX_W'(w))
                word_q <= word_q & cmd.data;
        end
        assign user_bits[w*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            viol   <= 1'b0;
        end else begin
            if (cmd.lock_fire)
                locked <= 1'b1;
            viol <= refused;
        end
    end

endmodule

// File: rtl/pr_read_port.sv
module pr_read_port
    import pr_pkg::*;
#(
    parameter logic [HALF_BITS-1:0] FIXED_VALUE = 64'h1234_5678_9ABC_DEF0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 id_mode,
    input  logic                 locked,
    input  logic [HALF_BITS-1:0] user_bits,
    output logic [WORD_W-1:0]    rdata
);

    logic [WORD_W-1:0] val;
    int unsigned       lsb;

    always_comb begin
        val = '1;
        lsb = 32'(word_idx(addr)) * WORD_W;
        if (id_mode) begin
            unique case (classify(addr))
                RG_STAT:  val[LOCK_BIT] = ~locked;
                RG_FIXED: val = FIXED_VALUE[lsb +: WORD_W];
                RG_USER:  val = user_bits[lsb +: WORD_W];
                default:  val = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '1;
        else if (rd_en)
            rdata <= val;
    end

endmodule

// File: rtl/prot_reg_top.sv
module prot_reg_top
    import pr_pkg::*;
#(
    parameter logic [HALF_BITS-1:0] FIXED_VALUE = 64'h1234_5678_9ABC_DEF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              prot_viol
);

    logic                 id_mode;
    cmd_t                 cmd;
    logic [HALF_BITS-1:0] user_bits;
    logic                 user_locked;

    pr_cmd_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .id_mode (id_mode),
        .cmd     (cmd)
    );

    pr_user_store store_i (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .user_bits (user_bits),
        .locked    (user_locked),
        .viol      (prot_viol)
    );

    pr_read_port #(.FIXED_VALUE(FIXED_VALUE)) rd_i (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .addr      (addr),
        .id_mode   (id_mode),
        .locked    (user_locked),
        .user_bits (user_bits),
        .rdata     (rdata)
    );

endmodule

// File: rtl/pr_chk.sv
module pr_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [11:0] addr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        prot_viol,
    input logic        id_mode,
    input logic        locked,
    input logic [63:0] user_bits
);

    // R4
    bits_only_fall_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((user_bits & ~$past(user_bits)) == 64'd0));

    // R8
    locked_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(user_bits) && locked));

    // R5
    viol_single_chk: assert property (@(posedge clk) disable iff (rst)
        prot_viol |=> !prot_viol);

    // R2
    closed_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !id_mode) |=> (rdata == 16'hFFFF));

    // R7
    lock_status_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && id_mode && addr == 12'h080) |=> (rdata[1] == !$past(locked)));

    // R9
    id_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (id_mode && !(wr_en && wdata[7:0] == 8'hF0)) |=> id_mode);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

bind prot_reg_top pr_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .prot_viol (prot_viol),
    .id_mode   (id_mode),
    .locked    (user_locked),
    .user_bits (user_bits)
);

// File: tb/prot_reg_top_tb.sv
module prot_reg_top_tb_top;

    localparam logic [63:0] FIXED = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        prot_viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic viol_seen;

    always #5 clk = ~clk;

    prot_reg_top #(.FIXED_VALUE(FIXED)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .prot_viol(prot_viol)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        viol_seen = prot_viol;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic keys(input logic [7:0] op);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, {8'h00, op});
    endtask

    task automatic id_in();  keys(8'h90); endtask
    task automatic id_out(); wr(12'h000, 16'h00F0); endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 rdata after reset", rdata, 16'hFFFF);
        rd(12'h081, d);
        check("R2 read outside id mode", d, 16'hFFFF);
        id_in();
        rd(12'h080, d);
        check("R1 unlocked at reset", d, 16'hFFFF);
        for (int i = 0; i < 4; i++) begin
            rd(12'h085 + 12'(i), d);
            check("R1 user half blank", d, 16'hFFFF);
        end
        id_out();
    endtask

    task automatic t_fixed_and_map();
        logic [15:0] d;
        id_in();
        for (int i = 0; i < 4; i++) begin
            rd(12'h081 + 12'(i), d);
            check("R3 fixed half word", d, FIXED[i*16 +: 16]);
        end
        rd(12'h07F, d);
        check("R11 below map", d, 16'hFFFF);
        rd(12'h089, d);
        check("R11 above map", d, 16'hFFFF);
        id_out();
    endtask

    task automatic t_id_ignores();
        logic [15:0] d;
        id_in();
        keys(8'hC0);
        wr(12'h085, 16'h0000);
        rd(12'h085, d);
        check("R9 program ignored in id mode", d, 16'hFFFF);
        rd(12'h082, d);
        check("R9 still in id mode", d, FIXED[31:16]);
        id_out();
        rd(12'h082, d);
        check("R9 exit leaves id mode", d, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [15:0] d;
        keys(8'hC0);
        wr(12'h085, 16'hF0F0);
        id_in(); rd(12'h085, d); id_out();
        check("R4 first program", d, 16'hF0F0);
        keys(8'hC0);
        wr(12'h085, 16'h0FFF);
        id_in(); rd(12'h085, d); id_out();
        check("R4 AND with old value", d, 16'h00F0);
        keys(8'hC0);
        wr(12'h088, 16'h1234);
        id_in(); rd(12'h088, d); rd(12'h086, d); id_out();
        check("R4 neighbour word untouched", d, 16'hFFFF);
        id_in(); rd(12'h088, d); id_out();
        check("R4 last word", d, 16'h1234);
    endtask

    task automatic t_broken();
        logic [15:0] d;
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0000);
        wr(12'h555, 16'h00C0);
        wr(12'h086, 16'h0000);
        id_in(); rd(12'h086, d); id_out();
        check("R10 broken sequence no effect", d, 16'hFFFF);
    endtask

    task automatic t_prog_fixed();
        logic [15:0] d;
        keys(8'hC0);
        wr(12'h081, 16'h0000);
        check("R5 violation pulse", {15'd0, viol_seen}, 16'd1);
        @(negedge clk);
        check("R5 pulse one cycle", {15'd0, prot_viol}, 16'd0);
        id_in(); rd(12'h081, d); id_out();
        check("R5 fixed half unchanged", d, FIXED[15:0]);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        keys(8'h60);
        wr(12'h000, 16'hFFFF);
        id_in(); rd(12'h080, d); id_out();
        check("R6 bit1 high does not lock", d, 16'hFFFF);
        keys(8'h60);
        wr(12'h000, 16'hFFFD);
        id_in(); rd(12'h080, d); id_out();
        check("R7 locked status", d, 16'hFFFD);
    endtask

    task automatic t_prog_locked();
        logic [15:0] d;
        keys(8'hC0);
        wr(12'h085, 16'h0000);
        check("R8 violation when locked", {15'd0, viol_seen}, 16'd1);
        id_in(); rd(12'h085, d); id_out();
        check("R8 locked word unchanged", d, 16'h00F0);
    endtask

    task automatic t_hold();
        logic [15:0] d;
        id_in();
        rd(12'h084, d);
        check("R12 read result", d, FIXED[63:48]);
        @(negedge clk); addr = 12'h081;
        @(negedge clk); @(negedge clk);
        check("R12 rdata holds", rdata, FIXED[63:48]);
        id_out();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed_and_map();
        t_id_ignores();
        t_program();
        t_broken();
        t_prog_fixed();
        t_lock();
        t_prog_locked();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule